// File: doc/BRIEF.md
# Nonvolatile Store Sequencer

This block decides when a request to save a value into the emulated nonvolatile data slots is carried out, and how long that save takes. A command front end sends it a one-cycle request while chip select is low. The request carries a kind code, a pot index, a slot index, host data and a snapshot of all wiper values. The sequencer records the request and waits. When chip select rises and the hardware protect pin is high, it starts a timed busy window. During that window a write-in-progress flag is set and is visible in a status byte.

The slot storage is written only once, in the last cycle of the busy window. A save can store one pot's host data or one pot's current wiper, or it can store every pot's wiper into the same slot index. A volatile wiper load passes through the block without any effect on it. While the window is running, new save requests are dropped.

Top module: `nv_commit_seq`

## Requirements
- R1: After reset, `wip`, `slotWe` and `statusByte` are all zero.
- R2: A captured save request does not start a cycle while `csN` is low. `wip` becomes 1 at the clock edge where `csN` is first sampled high after being low, provided a request is pending and `wpN` is high.
- R3: Once started, `wip` stays high for exactly `CYCLE_TICKS` clock cycles and then returns to 0.
- R4: Each cycle pulses `slotWe` in exactly one clock cycle, which is the last cycle in which `wip` is high. `slotWe` is never nonzero while `wip` is low.
- R5: Kind code 1 (host data write) asserts only `slotWe[reqPot]`. It presents `reqData` on lane `reqPot` of `slotData`, where lane p is bits `[p*DATA_W +: DATA_W]`, and presents `reqSlot` on `slotIdx`.
- R6: Kind code 2 (single wiper save) asserts only `slotWe[reqPot]`. Its lane carries the wiper value of that pot as it was in the request cycle, even if `wiperFlat` changes before chip select rises.
- R7: Kind code 3 (all wipers save) asserts every bit of `slotWe` in one cycle. Each lane carries its pot's wiper snapshot, and `slotIdx` carries `reqSlot`.
- R8: Kind code 0 (volatile wiper load) starts no cycle and writes nothing.
- R9: If `wpN` is low when chip select rises, no cycle starts, `wip` stays 0 and the request is discarded. A later chip select rise without a new request starts nothing.
- R10: A save request that arrives while `wip` is high is ignored. It causes no second cycle and no extra write.
- R11: `statusByte` bit 0 equals `wip`, and bits 7..1 are always 0.
- R12: A reset during a cycle clears `wip`, and no slot write takes place.
- R13: A chip select rise with no pending request starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Chip select, active low, synchronised to clk |
| wpN | input | 1 | Hardware write protect, low blocks saves |
| reqValid | input | 1 | One-cycle request strobe from the front end |
| reqKind | input | 2 | 0 volatile load, 1 host data write, 2 single wiper save, 3 all wipers save |
| reqPot | input | POT_W | Target pot index |
| reqSlot | input | SLOT_W | Target slot index |
| reqData | input | DATA_W | Host data for kind 1 |
| wiperFlat | input | NUM_POTS*DATA_W | Current wiper values, lane per pot |
| wip | output | 1 | Write in progress |
| statusByte | output | 8 | Status data byte, bit 0 is wip |
| slotWe | output | NUM_POTS | Per-pot slot write enable |
| slotIdx | output | SLOT_W | Slot index to write |
| slotData | output | NUM_POTS*DATA_W | Per-pot write data |

## Verification
The assertions check several rules on every cycle. A busy window always follows a high sample of chip select that came right after a low one, with protect high. The window lasts exactly the configured length. The single write pulse falls in its final cycle and never outside it, and the upper status bits stay zero. Other behaviour can only be shown by the bench's scenarios. These are which lanes are enabled for each kind code and the data each lane carries, the wiper snapshot being taken at request time, and requests being dropped under protect or during a busy window. The same holds for the effect of a reset in the middle of a cycle.

// File: rtl/nv_commit_pkg.sv
package nv_commit_pkg;
  typedef enum logic [1:0] {
    KIND_LOAD     = 2'd0,
    KIND_WRITE    = 2'd1,
    KIND_XFER_ONE = 2'd2,
    KIND_XFER_ALL = 2'd3
  } reqKind_e;

  typedef struct packed {
    logic capture;
    logic commit;
  } ctrlStrobe_t;
endpackage

// File: rtl/nv_commit_ctrl.sv
module nv_commit_ctrl
  import nv_commit_pkg::*;
#(
  parameter int CYCLE_TICKS = 500000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        wpN,
  input  logic        reqValid,
  input  logic [1:0]  reqKind,
  output logic        wip,
  output ctrlStrobe_t strobe
);
  localparam int CNT_W = $clog2(CYCLE_TICKS + 1);

  logic             csPrev;
  logic             pending;
  logic             busy;
  logic [CNT_W-1:0] ticksLeft;
  logic             csRise;
  logic             startCycle;
  reqKind_e         kind;

  assign kind       = reqKind_e'(reqKind);
  assign csRise     = csN & ~csPrev;
  assign startCycle = csRise & pending & wpN & ~busy;

  always_comb begin
    strobe.capture = reqValid & ~busy & (kind != KIND_LOAD);
    strobe.commit  = busy & (ticksLeft == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csPrev    <= 1'b1;
      pending   <= 1'b0;
      busy      <= 1'b0;
      ticksLeft <= '0;
    end else begin
      csPrev <= csN;
      if (csRise)              pending <= 1'b0;
      else if (strobe.capture) pending <= 1'b1;

      if (startCycle) begin
        busy      <= 1'b1;
        ticksLeft <= CNT_W'(CYCLE_TICKS - 1);
      end else if (strobe.commit) begin
        busy <= 1'b0;
      end else if (busy) begin
        ticksLeft <= ticksLeft - CNT_W'(1);
      end
    end
  end

  assign wip = busy;
endmodule

// File: rtl/nv_commit_data.sv
module nv_commit_data
  import nv_commit_pkg::*;
#(
  parameter int NUM_POTS = 4,
  parameter int DATA_W   = 6,
  parameter int SLOT_W   = 2,
  parameter int POT_W    = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobe_t                strobe,
  input  logic [1:0]                 reqKind,
  input  logic [POT_W-1:0]           reqPot,
  input  logic [SLOT_W-1:0]          reqSlot,
  input  logic [DATA_W-1:0]          reqData,
  input  logic [NUM_POTS*DATA_W-1:0] wiperFlat,
  output logic [NUM_POTS-1:0]        slotWe,
  output logic [SLOT_W-1:0]          slotIdx,
  output logic [NUM_POTS*DATA_W-1:0] slotData
);
  reqKind_e            kind;
  logic [SLOT_W-1:0]   slotQ;
  logic [NUM_POTS-1:0] laneMask;

  assign kind = reqKind_e'(reqKind);

  always_ff @(posedge clk) begin
    if (!rstN)               slotQ <= '0;
    else if (strobe.capture) slotQ <= reqSlot;
  end

  for (genvar p = 0; p < NUM_POTS; p++) begin : g_lane
    logic [DATA_W-1:0] laneQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        laneMask[p] <= 1'b0;
        laneQ       <= '0;
      end else if (strobe.capture) begin
        laneMask[p] <= (kind == KIND_XFER_ALL) || (reqPot == POT_W'(p));
        laneQ       <= (kind == KIND_WRITE) ? reqData
                                            : wiperFlat[p*DATA_W +: DATA_W];
      end
    end
    assign slotWe[p]                     = strobe.commit & laneMask[p];
    assign slotData[p*DATA_W +: DATA_W]  = laneQ;
  end

  assign slotIdx = slotQ;
endmodule

// File: rtl/nv_commit_seq.sv
module nv_commit_seq
  import nv_commit_pkg::*;
#(
  parameter int CYCLE_TICKS = 500000,
  parameter int NUM_POTS    = 4,
  parameter int DATA_W      = 6,
  parameter int SLOT_W      = 2,
  parameter int POT_W       = (NUM_POTS > 1) ? $clog2(NUM_POTS) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       csN,
  input  logic                       wpN,
  input  logic                       reqValid,
  input  logic [1:0]                 reqKind,
  input  logic [POT_W-1:0]           reqPot,
  input  logic [SLOT_W-1:0]          reqSlot,
  input  logic [DATA_W-1:0]          reqData,
  input  logic [NUM_POTS*DATA_W-1:0] wiperFlat,
  output logic                       wip,
  output logic [7:0]                 statusByte,
  output logic [NUM_POTS-1:0]        slotWe,
  output logic [SLOT_W-1:0]          slotIdx,
  output logic [NUM_POTS*DATA_W-1:0] slotData
);
  ctrlStrobe_t strobe;

  nv_commit_ctrl #(.CYCLE_TICKS(CYCLE_TICKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .wpN(wpN),
    .reqValid(reqValid), .reqKind(reqKind),
    .wip(wip), .strobe(strobe)
  );

  nv_commit_data #(
    .NUM_POTS(NUM_POTS), .DATA_W(DATA_W), .SLOT_W(SLOT_W), .POT_W(POT_W)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqKind(reqKind), .reqPot(reqPot), .reqSlot(reqSlot), .reqData(reqData),
    .wiperFlat(wiperFlat),
    .slotWe(slotWe), .slotIdx(slotIdx), .slotData(slotData)
  );

  assign statusByte = {7'b0000000, wip};
endmodule

// File: rtl/nv_commit_chk.sv
module nv_commit_chk #(
  parameter int CYCLE_TICKS = 500000,
  parameter int NUM_POTS    = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                csN,
  input logic                wpN,
  input logic                wip,
  input logic [7:0]          statusByte,
  input logic [NUM_POTS-1:0] slotWe
);
  int unsigned busyLen;

  always_ff @(posedge clk) begin
    if (!rstN)    busyLen <= 0;
    else if (wip) busyLen <= busyLen + 1;
    else          busyLen <= 0;
  end

  // R2
  start_after_cs_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wip) |-> ($past(csN) && !$past(csN, 2)));

  // R9
  start_needs_wp_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wip) |-> $past(wpN));

  // R3
  busy_length_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wip) |-> (busyLen == CYCLE_TICKS));

  // R4
  write_only_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (slotWe != '0) |-> wip);

  // R4
  write_last_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (slotWe != '0) |-> (busyLen == CYCLE_TICKS - 1));

  // R4
  write_then_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (slotWe != '0) |=> (!wip && slotWe == '0));

  // R11
  status_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[7:1] == 7'd0);
endmodule

bind nv_commit_seq nv_commit_chk #(
  .CYCLE_TICKS(CYCLE_TICKS), .NUM_POTS(NUM_POTS)
) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .wpN(wpN),
  .wip(wip), .statusByte(statusByte), .slotWe(slotWe)
);

// File: tb/nv_commit_seq_test.sv
module nv_commit_seq_test;
  localparam int CT = 12;
  localparam int NP = 4;
  localparam int DW = 6;
  localparam int SW = 2;

  typedef struct packed {
    logic [1:0] kind;
    logic [1:0] pot;
    logic [1:0] slot;
    logic [5:0] data;
    logic       wp;
    logic       expStart;
    logic [3:0] expMask;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd1, 2'd2, 2'd1, 6'h2A, 1'b1, 1'b1, 4'b0100},
    '{2'd2, 2'd1, 2'd3, 6'h00, 1'b1, 1'b1, 4'b0010},
    '{2'd3, 2'd0, 2'd2, 6'h00, 1'b1, 1'b1, 4'b1111},
    '{2'd0, 2'd1, 2'd1, 6'h11, 1'b1, 1'b0, 4'b0000},
    '{2'd1, 2'd3, 2'd0, 6'h15, 1'b0, 1'b0, 4'b0000},
    '{2'd2, 2'd0, 2'd0, 6'h00, 1'b1, 1'b1, 4'b0001},
    '{2'd1, 2'd3, 2'd0, 6'h3F, 1'b1, 1'b1, 4'b1000},
    '{2'd3, 2'd0, 2'd3, 6'h00, 1'b0, 1'b0, 4'b0000}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic wpN = 1'b1;
  logic reqValid = 1'b0;
  logic [1:0] reqKind = '0;
  logic [1:0] reqPot = '0;
  logic [SW-1:0] reqSlot = '0;
  logic [DW-1:0] reqData = '0;
  logic [NP*DW-1:0] wiperFlat = '0;
  logic wip;
  logic [7:0] statusByte;
  logic [NP-1:0] slotWe;
  logic [SW-1:0] slotIdx;
  logic [NP*DW-1:0] slotData;

  int compared = 0;
  int mismatched = 0;
  int statusBad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  nv_commit_seq #(.CYCLE_TICKS(CT), .NUM_POTS(NP), .DATA_W(DW), .SLOT_W(SW)) uut (
    .clk(clk), .rstN(rstN), .csN(csN), .wpN(wpN), .reqValid(reqValid),
    .reqKind(reqKind), .reqPot(reqPot), .reqSlot(reqSlot), .reqData(reqData),
    .wiperFlat(wiperFlat), .wip(wip), .statusByte(statusByte),
    .slotWe(slotWe), .slotIdx(slotIdx), .slotData(slotData)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] lanePattern(input int idx, input int p);
    return DW'((idx * 7 + p * 13 + 5) & 63);
  endfunction

  function automatic logic [NP*DW-1:0] wiperPattern(input int idx);
    logic [NP*DW-1:0] w;
    for (int p = 0; p < NP; p++) w[p*DW +: DW] = lanePattern(idx, p);
    return w;
  endfunction

  // cs low, one request strobe, scramble wipers, cs high
  task automatic frame(input logic [1:0] k, input logic [1:0] p,
                       input logic [1:0] s, input logic [5:0] d);
    @(negedge clk); csN = 1'b0;
    @(negedge clk); reqValid = 1'b1; reqKind = k; reqPot = p; reqSlot = s; reqData = d;
    @(negedge clk); reqValid = 1'b0; wiperFlat = ~wiperFlat;
    @(negedge clk); csN = 1'b1;
  endtask

  task automatic observe(input int n, output int busyCnt, output int weCnt,
                         output logic [NP-1:0] mask, output logic [SW-1:0] slot,
                         output logic [NP*DW-1:0] data);
    busyCnt = 0; weCnt = 0; mask = '0; slot = '0; data = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (statusByte != {7'b0, wip}) statusBad++;
      if (wip) busyCnt++;
      if (slotWe != '0) begin
        weCnt++; mask = slotWe; slot = slotIdx; data = slotData;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int bc, wc;
    logic [NP-1:0] m;
    logic [SW-1:0] s;
    logic [NP*DW-1:0] d;
    vec_t v;

    repeat (3) @(negedge clk);
    // R12: no write strobe while held in reset
    check(slotWe == '0, "R12", int'(slotWe), 0);
    rstN = 1'b1;
    @(negedge clk);
    // R1 / R11: reset state
    check(wip == 1'b0 && slotWe == '0, "R1", int'({wip, slotWe}), 0);
    check(statusByte == 8'h00, "R11", int'(statusByte), 0);

    // vector table
    for (int i = 0; i < 8; i++) begin
      v = VECS[i];
      wpN = v.wp;
      wiperFlat = wiperPattern(i);
      frame(v.kind, v.pot, v.slot, v.data);
      // R2: csN raised at this negedge, no cycle yet
      check(wip == 1'b0, "R2", int'(wip), 0);
      observe(CT + 4, bc, wc, m, s, d);
      wpN = 1'b1;
      if (v.expStart) begin
        check(bc == CT, "R3", bc, CT);
        check(wc == 1, "R4", wc, 1);
        check(m == v.expMask, v.kind == 2'd1 ? "R5" : (v.kind == 2'd2 ? "R6" : "R7"),
              int'(m), int'(v.expMask));
        check(s == v.slot, "R5", int'(s), int'(v.slot));
        for (int p = 0; p < NP; p++) begin
          if (v.expMask[p]) begin
            logic [DW-1:0] e;
            e = (v.kind == 2'd1) ? v.data : lanePattern(i, p);
            check(d[p*DW +: DW] == e, v.kind == 2'd1 ? "R5" : (v.kind == 2'd2 ? "R6" : "R7"),
                  int'(d[p*DW +: DW]), int'(e));
          end
        end
      end else begin
        check(bc == 0 && wc == 0, v.wp ? "R8" : "R9", bc + wc, 0);
      end
      // R9: a bare CS pulse after a blocked request starts nothing
      if (!v.wp) begin
        @(negedge clk); csN = 1'b0;
        @(negedge clk); csN = 1'b1;
        observe(CT + 2, bc, wc, m, s, d);
        check(bc == 0 && wc == 0, "R9", bc + wc, 0);
      end
    end

    // R13: CS pulse with nothing pending
    @(negedge clk); csN = 1'b0;
    @(negedge clk); csN = 1'b1;
    observe(CT + 2, bc, wc, m, s, d);
    check(bc == 0 && wc == 0, "R13", bc + wc, 0);

    // R10: second request during busy is dropped
    wiperFlat = wiperPattern(20);
    frame(2'd1, 2'd0, 2'd1, 6'h05);
    frame(2'd1, 2'd1, 2'd2, 6'h09);
    observe(CT + 4, bc, wc, m, s, d);
    check(wc == 1 && m == 4'b0001, "R10", int'(m), 1);
    check(d[DW-1:0] == 6'h05 && s == 2'd1, "R10", int'(d[DW-1:0]), 5);
    @(negedge clk); csN = 1'b0;
    @(negedge clk); csN = 1'b1;
    observe(CT + 2, bc, wc, m, s, d);
    check(bc == 0 && wc == 0, "R10", bc + wc, 0);

    // R12: reset in the middle of a cycle
    frame(2'd3, 2'd0, 2'd2, 6'h00);
    repeat (4) @(negedge clk);
    check(wip == 1'b1, "R12", int'(wip), 1);
    rstN = 1'b0;
    @(negedge clk);
    check(slotWe == '0, "R12", int'(slotWe), 0);
    @(negedge clk);
    rstN = 1'b1;
    observe(CT + 4, bc, wc, m, s, d);
    check(bc == 0 && wc == 0, "R12", bc + wc, 0);

    // R11: status byte tracked wip in every observed cycle
    check(statusBad == 0, "R11", statusBad, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule